// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block is the power-manager state machine of a microcontroller. It keeps the chip in one of five power states: Active, Idle, Standby, Backup and Off. A stored sleep-level field picks the target level. The CPU moves the block into that level with a wait-for-interrupt strobe. For Idle and Standby it can also do so by leaving its lowest-priority interrupt handler while the sleep-on-exit enable is set.

In every state the block drives registered enables for the CPU clock, the main clock, each peripheral bus clock, each generic clock and each oscillator. It also drives a regulator-mode code, an NVM power code, a backup-domain flag and a one-hot state status.

Each state has its own set of wake-up sources. Idle and Standby return to Active on their wake-up interrupts. Backup returns only on a backup reset indication, and Off returns only through the external reset pin. In Standby the block keeps serving clock and power requests from peripherals that run while the CPU sleeps (sleepwalking).

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: While the power-on reset is held, and in the first cycle after it, the block is Active. The CPU and main clocks are on, every bus and generic clock enable is 1, the regulator code is 1 (main, normal), the NVM code is 2 (active), and the I/O retention output is 0.
- R2: A WFI strobe in Active enters the level held in the mode field on the next clock edge. The field encodes 0 as Idle, 1 as Standby, 2 as Backup and 3 as Off, and 4 to 7 are treated as Idle. Without a WFI strobe or a qualifying sleep-on-exit event, the block never leaves Active.
- R3: With the sleep-on-exit enable set, a handler-exit strobe enters Idle or Standby exactly as WFI would. When Backup or Off is selected, the strobe has no effect.
- R4: In Idle, the CPU clock is off and the main clock is on. Each bus clock enable follows that peripheral's clock request. All generic clocks are on, and each oscillator follows its request. The regulator code is 1 and the NVM code is 2. The CPU clock is on only in Active.
- R5: In Idle, any synchronous interrupt or the asynchronous interrupt returns the block to Active on the next edge, with every bus and generic clock enable back at 1.
- R6: In Standby, a bus clock is enabled only where the peripheral both requests it and has its run-in-standby flag set. The main clock is on exactly when some such bus clock is. Generic clocks follow their requests. An oscillator runs if it is requested or its run-in-standby flag is set. The NVM code is 1 (ultra-low power).
- R7: In Standby, the regulator code is 2 (main, low power) and changes to 1 in the cycle after a sleepwalking power request. It returns to 2 when the request ends.
- R8: Standby wakes to Active on the asynchronous interrupt, or on a synchronous interrupt from a peripheral whose run-in-standby flag is set. A synchronous interrupt from any other peripheral is ignored.
- R9: In Backup, every clock and oscillator enable is 0, the regulator code is 3 (backup regulator), the NVM code is 0 (off) and the backup-domain flag is 1. Only a backup reset indication (or the external reset pin) leaves Backup.
- R10: Entering Backup returns the mode field to Idle (0) and keeps the I/O retention bit unchanged.
- R11: In Off, every enable is 0, the regulator and NVM codes are 0 and the backup-domain flag is 0. Only the external reset pin (active low) leaves Off.
- R12: The external reset pin, sampled low in any state, returns the block to Active on the next edge. It also clears the mode field to Idle and the I/O retention bit to 0.
- R13: A WFI strobe in Active is cancelled, and the block stays in Active, when a wake-up source of the selected level is present in the same cycle.
- R14: The state status has exactly one bit set: bit 0 Active, bit 1 Idle, bit 2 Standby, bit 3 Backup, bit 4 Off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst_n | input | 1 | External reset pin, sampled, active low |
| cfg_we_i | input | 1 | Load the mode field and retention bit |
| cfg_mode_i | input | 3 | Sleep level to store |
| cfg_ioret_i | input | 1 | I/O retention bit to store |
| wfi_i | input | 1 | Wait-for-interrupt strobe from the CPU |
| soe_en_i | input | 1 | Sleep-on-exit enable |
| handler_exit_i | input | 1 | Strobe: CPU leaves its lowest-priority handler |
| periph_clk_req_i | input | NP | Per-peripheral bus clock request |
| periph_run_stdby_i | input | NP | Per-peripheral run-in-standby flag |
| gclk_req_i | input | NG | Generic clock requests |
| osc_req_i | input | NO | Oscillator requests |
| osc_run_stdby_i | input | NO | Oscillator run-in-standby flags |
| sync_irq_i | input | NP | Unmasked bus-clock interrupts per peripheral |
| async_irq_i | input | 1 | Unmasked asynchronous interrupt |
| backup_rst_i | input | 1 | Backup reset indication |
| sw_pwr_req_i | input | 1 | Sleepwalking task needs full regulator power |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| main_clk_en_o | output | 1 | Main clock enable |
| bus_clk_en_o | output | NP | Bus clock enable per peripheral |
| gclk_en_o | output | NG | Generic clock enables |
| osc_en_o | output | NO | Oscillator enables |
| reg_mode_o | output | 2 | 0 off, 1 main normal, 2 main low power, 3 backup |
| nvm_state_o | output | 2 | 0 off, 1 ultra-low power, 2 active |
| backup_dom_o | output | 1 | Only the backup domain is powered |
| state_onehot_o | output | 5 | One-hot power state |
| io_ret_o | output | 1 | I/O retention bit |

## Verification
The checker watches the state rules on every cycle. It checks that Active is held without a sleep request, and that Idle wakes on any interrupt. It checks that Standby ignores interrupts from peripherals not marked to run in standby, and that Backup and Off hold until their own reset. It also checks the external reset return, the CPU clock being on only in Active, the Standby regulator tracking the sleepwalking request, the quiet Backup outputs and the one-hot status. Only the bench scenarios can show the rest. That covers the exact gating patterns for given request vectors, the decoding of the mode field with unused codes falling to Idle, and the sleep-on-exit path with its refusal for the deep levels. It also covers cancellation by a simultaneous wake-up, and the mode field returning to Idle on Backup entry, which shows up only at the next WFI.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE  = 3'd0,
        ST_IDLE    = 3'd1,
        ST_STANDBY = 3'd2,
        ST_BACKUP  = 3'd3,
        ST_OFF     = 3'd4
    } pstate_e;

    localparam int NUM_STATES = 5;

    // stored sleep-level codes
    localparam logic [2:0] LVL_IDLE    = 3'd0;
    localparam logic [2:0] LVL_STANDBY = 3'd1;
    localparam logic [2:0] LVL_BACKUP  = 3'd2;
    localparam logic [2:0] LVL_OFF     = 3'd3;

    // regulator codes
    localparam logic [1:0] REG_OFF    = 2'd0;
    localparam logic [1:0] REG_NORMAL = 2'd1;
    localparam logic [1:0] REG_LOWPWR = 2'd2;
    localparam logic [1:0] REG_BACKUP = 2'd3;

    // NVM codes
    localparam logic [1:0] NVM_OFF    = 2'd0;
    localparam logic [1:0] NVM_ULP    = 2'd1;
    localparam logic [1:0] NVM_ACTIVE = 2'd2;

    function automatic pstate_e level_to_state(input logic [2:0] lvl);
        pstate_e s;
        case (lvl)
            LVL_STANDBY: s = ST_STANDBY;
            LVL_BACKUP:  s = ST_BACKUP;
            LVL_OFF:     s = ST_OFF;
            default:     s = ST_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pwr_wake_eval.sv
module pwr_wake_eval
    import pwr_sleep_pkg::*;
#(
    parameter int NP = 4
) (
    input  pstate_e         cur_state,
    input  pstate_e         tgt_state,
    input  logic [NP-1:0]   sync_irq,
    input  logic [NP-1:0]   run_stdby,
    input  logic            async_irq,
    input  logic            backup_rst,
    output logic            wake_cur,
    output logic            cancel_tgt
);

    logic idle_wake;
    logic stby_wake;

    assign idle_wake = (|sync_irq) | async_irq;
    assign stby_wake = async_irq | (|(sync_irq & run_stdby));

    // wake-up for the state presently held
    always_comb begin
        case (cur_state)
            ST_IDLE:    wake_cur = idle_wake;
            ST_STANDBY: wake_cur = stby_wake;
            ST_BACKUP:  wake_cur = backup_rst;
            default:    wake_cur = 1'b0;
        endcase
    end

    // wake-up of the level about to be entered cancels the entry
    always_comb begin
        case (tgt_state)
            ST_IDLE:    cancel_tgt = idle_wake;
            ST_STANDBY: cancel_tgt = stby_wake;
            ST_BACKUP:  cancel_tgt = backup_rst;
            default:    cancel_tgt = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwr_gate_plan.sv
module pwr_gate_plan
    import pwr_sleep_pkg::*;
#(
    parameter int NP = 4,
    parameter int NG = 3,
    parameter int NO = 2
) (
    input  pstate_e                 nxt_state,
    input  logic [NP-1:0]           periph_clk_req,
    input  logic [NP-1:0]           periph_run_stdby,
    input  logic [NG-1:0]           gclk_req,
    input  logic [NO-1:0]           osc_req,
    input  logic [NO-1:0]           osc_run_stdby,
    input  logic                    sw_pwr_req,
    output logic                    cpu_en,
    output logic                    main_en,
    output logic [NP-1:0]           bus_en,
    output logic [NG-1:0]           gclk_en,
    output logic [NO-1:0]           osc_en,
    output logic [1:0]              reg_mode,
    output logic [1:0]              nvm_state,
    output logic                    bkdom,
    output logic [NUM_STATES-1:0]   onehot
);

    logic [NP-1:0] walk_bus;

    assign walk_bus = periph_clk_req & periph_run_stdby;

    always_comb begin
        cpu_en    = 1'b0;
        main_en   = 1'b0;
        bus_en    = '0;
        gclk_en   = '0;
        osc_en    = '0;
        reg_mode  = REG_OFF;
        nvm_state = NVM_OFF;
        bkdom     = 1'b0;
        case (nxt_state)
            ST_ACTIVE: begin
                cpu_en    = 1'b1;
                main_en   = 1'b1;
                bus_en    = '1;
                gclk_en   = '1;
                osc_en    = osc_req;
                reg_mode  = REG_NORMAL;
                nvm_state = NVM_ACTIVE;
            end
            ST_IDLE: begin
                main_en   = 1'b1;
                bus_en    = periph_clk_req;
                gclk_en   = '1;
                osc_en    = osc_req;
                reg_mode  = REG_NORMAL;
                nvm_state = NVM_ACTIVE;
            end
            ST_STANDBY: begin
                main_en   = |walk_bus;
                bus_en    = walk_bus;
                gclk_en   = gclk_req;
                osc_en    = osc_req | osc_run_stdby;
                reg_mode  = sw_pwr_req ? REG_NORMAL : REG_LOWPWR;
                nvm_state = NVM_ULP;
            end
            ST_BACKUP: begin
                reg_mode  = REG_BACKUP;
                bkdom     = 1'b1;
            end
            default: begin
            end
        endcase
    end

    for (genvar i = 0; i < NUM_STATES; i++) begin : g_onehot
        assign onehot[i] = (nxt_state == pstate_e'(i));
    end

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int NP = 4,
    parameter int NG = 3,
    parameter int NO = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_rst_n,
    input  logic            cfg_we_i,
    input  logic [2:0]      cfg_mode_i,
    input  logic            cfg_ioret_i,
    input  logic            wfi_i,
    input  logic            soe_en_i,
    input  logic            handler_exit_i,
    input  logic [NP-1:0]   periph_clk_req_i,
    input  logic [NP-1:0]   periph_run_stdby_i,
    input  logic [NG-1:0]   gclk_req_i,
    input  logic [NO-1:0]   osc_req_i,
    input  logic [NO-1:0]   osc_run_stdby_i,
    input  logic [NP-1:0]   sync_irq_i,
    input  logic            async_irq_i,
    input  logic            backup_rst_i,
    input  logic            sw_pwr_req_i,
    output logic            cpu_clk_en_o,
    output logic            main_clk_en_o,
    output logic [NP-1:0]   bus_clk_en_o,
    output logic [NG-1:0]   gclk_en_o,
    output logic [NO-1:0]   osc_en_o,
    output logic [1:0]      reg_mode_o,
    output logic [1:0]      nvm_state_o,
    output logic            backup_dom_o,
    output logic [4:0]      state_onehot_o,
    output logic            io_ret_o
);

    typedef struct packed {
        pstate_e    state;
        logic [2:0] mode;
        logic       ioret;
    } ctl_t;

    typedef struct packed {
        logic                   cpu;
        logic                   main;
        logic [NP-1:0]          bus;
        logic [NG-1:0]          gclk;
        logic [NO-1:0]          osc;
        logic [1:0]             regm;
        logic [1:0]             nvm;
        logic                   bkdom;
        logic [NUM_STATES-1:0]  st;
    } out_t;

    localparam ctl_t CTL_RST = '{state: ST_ACTIVE, mode: LVL_IDLE, ioret: 1'b0};
    localparam out_t OUT_RST = '{cpu: 1'b1, main: 1'b1, bus: '1, gclk: '1, osc: '1,
                                 regm: REG_NORMAL, nvm: NVM_ACTIVE, bkdom: 1'b0,
                                 st: NUM_STATES'(1)};

    ctl_t    ctl_d, ctl_q;
    out_t    out_d, out_q;
    pstate_e tgt_state;
    logic    wake_cur;
    logic    cancel_tgt;
    logic    sleep_go;

    assign tgt_state = level_to_state(ctl_q.mode);

    // sleep-on-exit reaches only the two shallow levels
    assign sleep_go = wfi_i |
                      (soe_en_i & handler_exit_i &
                       ((tgt_state == ST_IDLE) | (tgt_state == ST_STANDBY)));

    pwr_wake_eval #(.NP(NP)) u_wake (
        .cur_state  (ctl_q.state),
        .tgt_state  (tgt_state),
        .sync_irq   (sync_irq_i),
        .run_stdby  (periph_run_stdby_i),
        .async_irq  (async_irq_i),
        .backup_rst (backup_rst_i),
        .wake_cur   (wake_cur),
        .cancel_tgt (cancel_tgt)
    );

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.state)
            ST_ACTIVE: begin
                if (sleep_go && !cancel_tgt) ctl_d.state = tgt_state;
            end
            ST_IDLE, ST_STANDBY, ST_BACKUP: begin
                if (wake_cur) ctl_d.state = ST_ACTIVE;
            end
            default: begin
            end
        endcase
        if (cfg_we_i) begin
            ctl_d.mode  = cfg_mode_i;
            ctl_d.ioret = cfg_ioret_i;
        end
        if (ctl_d.state == ST_BACKUP && ctl_q.state != ST_BACKUP) begin
            ctl_d.mode = LVL_IDLE;
        end
        if (!ext_rst_n) begin
            ctl_d = CTL_RST;
        end
    end

    pwr_gate_plan #(.NP(NP), .NG(NG), .NO(NO)) u_plan (
        .nxt_state        (ctl_d.state),
        .periph_clk_req   (periph_clk_req_i),
        .periph_run_stdby (periph_run_stdby_i),
        .gclk_req         (gclk_req_i),
        .osc_req          (osc_req_i),
        .osc_run_stdby    (osc_run_stdby_i),
        .sw_pwr_req       (sw_pwr_req_i),
        .cpu_en           (out_d.cpu),
        .main_en          (out_d.main),
        .bus_en           (out_d.bus),
        .gclk_en          (out_d.gclk),
        .osc_en           (out_d.osc),
        .reg_mode         (out_d.regm),
        .nvm_state        (out_d.nvm),
        .bkdom            (out_d.bkdom),
        .onehot           (out_d.st)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
            out_q <= OUT_RST;
        end else begin
            ctl_q <= ctl_d;
            out_q <= out_d;
        end
    end

    assign cpu_clk_en_o   = out_q.cpu;
    assign main_clk_en_o  = out_q.main;
    assign bus_clk_en_o   = out_q.bus;
    assign gclk_en_o      = out_q.gclk;
    assign osc_en_o       = out_q.osc;
    assign reg_mode_o     = out_q.regm;
    assign nvm_state_o    = out_q.nvm;
    assign backup_dom_o   = out_q.bkdom;
    assign state_onehot_o = out_q.st;
    assign io_ret_o       = ctl_q.ioret;

endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk #(
    parameter int NP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ext_rst_n,
    input logic          wfi_i,
    input logic          soe_en_i,
    input logic          handler_exit_i,
    input logic [NP-1:0] sync_irq_i,
    input logic [NP-1:0] periph_run_stdby_i,
    input logic          async_irq_i,
    input logic          backup_rst_i,
    input logic          sw_pwr_req_i,
    input logic          cpu_clk_en_o,
    input logic          main_clk_en_o,
    input logic [1:0]    reg_mode_o,
    input logic [1:0]    nvm_state_o,
    input logic          backup_dom_o,
    input logic [4:0]    state_onehot_o
);

    logic st_act, st_idl, st_stb, st_bkp, st_off;
    assign st_act = state_onehot_o[0];
    assign st_idl = state_onehot_o[1];
    assign st_stb = state_onehot_o[2];
    assign st_bkp = state_onehot_o[3];
    assign st_off = state_onehot_o[4];

    assert_onehot_R14: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_onehot_o) == 1);

    assert_hold_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_act && !wfi_i && !(soe_en_i && handler_exit_i)) |=> st_act);

    assert_cpu_only_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en_o |-> st_act);

    assert_idle_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idl && ((|sync_irq_i) || async_irq_i)) |=> st_act);

    assert_stby_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_stb |-> (reg_mode_o == ($past(sw_pwr_req_i) ? 2'd1 : 2'd2)));

    assert_stby_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_stb && ext_rst_n && !async_irq_i &&
         ((sync_irq_i & periph_run_stdby_i) == '0)) |=> st_stb);

    assert_stby_async_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_stb && async_irq_i) |=> st_act);

    assert_backup_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_bkp && ext_rst_n && !backup_rst_i) |=> st_bkp);

    assert_backup_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_bkp |-> (!main_clk_en_o && reg_mode_o == 2'd3 &&
                    nvm_state_o == 2'd0 && backup_dom_o));

    assert_off_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_off && ext_rst_n) |=> st_off);

    assert_ext_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rst_n |=> st_act);

endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk #(.NP(NP)) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .ext_rst_n          (ext_rst_n),
    .wfi_i              (wfi_i),
    .soe_en_i           (soe_en_i),
    .handler_exit_i     (handler_exit_i),
    .sync_irq_i         (sync_irq_i),
    .periph_run_stdby_i (periph_run_stdby_i),
    .async_irq_i        (async_irq_i),
    .backup_rst_i       (backup_rst_i),
    .sw_pwr_req_i       (sw_pwr_req_i),
    .cpu_clk_en_o       (cpu_clk_en_o),
    .main_clk_en_o      (main_clk_en_o),
    .reg_mode_o         (reg_mode_o),
    .nvm_state_o        (nvm_state_o),
    .backup_dom_o       (backup_dom_o),
    .state_onehot_o     (state_onehot_o)
);

// File: tb/pwr_sleep_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl_tb;

    localparam int NP = 4;
    localparam int NG = 3;
    localparam int NO = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_rst_n = 1'b1;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_mode = '0;
    logic cfg_ioret = 1'b0;
    logic wfi = 1'b0;
    logic soe_en = 1'b0;
    logic hexit = 1'b0;
    logic [NP-1:0] pclk_req = '0;
    logic [NP-1:0] prs = '0;
    logic [NG-1:0] greq = '0;
    logic [NO-1:0] oreq = '0;
    logic [NO-1:0] ors = '0;
    logic [NP-1:0] sirq = '0;
    logic airq = 1'b0;
    logic brst = 1'b0;
    logic swreq = 1'b0;

    logic cpu_en, main_en, bkdom, ioret;
    logic [NP-1:0] bus_en;
    logic [NG-1:0] gclk_en;
    logic [NO-1:0] osc_en;
    logic [1:0] regm, nvm;
    logic [4:0] st;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    pwr_sleep_ctrl #(.NP(NP), .NG(NG), .NO(NO)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
        .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode), .cfg_ioret_i(cfg_ioret),
        .wfi_i(wfi), .soe_en_i(soe_en), .handler_exit_i(hexit),
        .periph_clk_req_i(pclk_req), .periph_run_stdby_i(prs),
        .gclk_req_i(greq), .osc_req_i(oreq), .osc_run_stdby_i(ors),
        .sync_irq_i(sirq), .async_irq_i(airq), .backup_rst_i(brst),
        .sw_pwr_req_i(swreq),
        .cpu_clk_en_o(cpu_en), .main_clk_en_o(main_en), .bus_clk_en_o(bus_en),
        .gclk_en_o(gclk_en), .osc_en_o(osc_en), .reg_mode_o(regm),
        .nvm_state_o(nvm), .backup_dom_o(bkdom), .state_onehot_o(st),
        .io_ret_o(ioret)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [2:0] m, input logic r);
        cfg_mode = m; cfg_ioret = r; cfg_we = 1'b1;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_wfi();
        wfi = 1'b1;
        step();
        wfi = 1'b0;
    endtask

    task automatic t_reset();
        // R1: values held by reset, sampled before the first active edge
        chk("R1", "state", st, 5'b00001);
        chk("R1", "cpu", cpu_en, 1);
        chk("R1", "main", main_en, 1);
        chk("R1", "bus", bus_en, 4'hF);
        chk("R1", "gclk", gclk_en, 3'h7);
        chk("R1", "reg", regm, 1);
        chk("R1", "nvm", nvm, 2);
        chk("R1", "ioret", ioret, 0);
        step();
        chk("R2", "stays active without request", st, 5'b00001);
    endtask

    task automatic t_idle();
        wr_cfg(3'd0, 1'b0);
        pclk_req = 4'b0101; oreq = 2'b01;
        pulse_wfi();
        chk("R2", "idle entered", st, 5'b00010);
        chk("R4", "cpu off", cpu_en, 0);
        chk("R4", "main on", main_en, 1);
        chk("R4", "bus follows req", bus_en, 4'b0101);
        chk("R4", "gclk on", gclk_en, 3'h7);
        chk("R4", "osc follows req", osc_en, 2'b01);
        chk("R4", "reg", regm, 1);
        chk("R4", "nvm", nvm, 2);
        step();
        chk("R5", "no irq keeps idle", st, 5'b00010);
        sirq = 4'b0010;
        step();
        sirq = '0;
        chk("R5", "sync irq wakes", st, 5'b00001);
        chk("R5", "cpu restored", cpu_en, 1);
        chk("R5", "bus restored", bus_en, 4'hF);
        pclk_req = '0; oreq = '0;
    endtask

    task automatic t_unused_code();
        wr_cfg(3'd6, 1'b0);
        pulse_wfi();
        chk("R2", "code 6 acts as idle", st, 5'b00010);
        airq = 1'b1;
        step();
        airq = 1'b0;
        chk("R5", "async irq wakes idle", st, 5'b00001);
    endtask

    task automatic t_soe();
        wr_cfg(3'd1, 1'b0);
        soe_en = 1'b1; hexit = 1'b1;
        step();
        hexit = 1'b0;
        chk("R3", "exit enters standby", st, 5'b00100);
        airq = 1'b1;
        step();
        airq = 1'b0;
        wr_cfg(3'd2, 1'b0);
        hexit = 1'b1;
        step();
        hexit = 1'b0;
        chk("R3", "exit ignored for backup", st, 5'b00001);
        step();
        chk("R3", "still active", st, 5'b00001);
        soe_en = 1'b0;
    endtask

    task automatic t_standby();
        wr_cfg(3'd1, 1'b0);
        pclk_req = 4'b1111; prs = 4'b0011; greq = 3'b010; oreq = 2'b01; ors = 2'b10;
        pulse_wfi();
        chk("R6", "standby entered", st, 5'b00100);
        chk("R6", "bus only run-in-standby", bus_en, 4'b0011);
        chk("R6", "main for sleepwalk", main_en, 1);
        chk("R6", "gclk follows req", gclk_en, 3'b010);
        chk("R6", "osc req or rs", osc_en, 2'b11);
        chk("R6", "nvm ulp", nvm, 1);
        chk("R7", "reg low power", regm, 2);
        swreq = 1'b1;
        step();
        chk("R7", "reg normal on request", regm, 1);
        swreq = 1'b0;
        step();
        chk("R7", "reg back to low power", regm, 2);
        pclk_req = 4'b1100;
        step();
        chk("R6", "main off with no walk", main_en, 0);
        sirq = 4'b0100;
        step();
        chk("R8", "non-rs sync irq ignored", st, 5'b00100);
        sirq = 4'b0001;
        step();
        sirq = '0;
        chk("R8", "rs sync irq wakes", st, 5'b00001);
        pclk_req = '0; prs = '0; greq = '0; oreq = '0; ors = '0;
    endtask

    task automatic t_cancel();
        wr_cfg(3'd0, 1'b0);
        wfi = 1'b1; airq = 1'b1;
        step();
        wfi = 1'b0; airq = 1'b0;
        chk("R13", "wfi cancelled", st, 5'b00001);
        chk("R13", "cpu kept", cpu_en, 1);
    endtask

    task automatic t_backup();
        wr_cfg(3'd2, 1'b1);
        pulse_wfi();
        chk("R9", "backup entered", st, 5'b01000);
        chk("R9", "clocks off", {cpu_en, main_en, bus_en, gclk_en, osc_en}, 0);
        chk("R9", "reg backup", regm, 3);
        chk("R9", "nvm off", nvm, 0);
        chk("R9", "backup domain", bkdom, 1);
        airq = 1'b1; sirq = 4'hF;
        step();
        airq = 1'b0; sirq = '0;
        chk("R9", "irq ignored", st, 5'b01000);
        brst = 1'b1;
        step();
        brst = 1'b0;
        chk("R9", "backup reset wakes", st, 5'b00001);
        chk("R10", "ioret kept", ioret, 1);
        pulse_wfi();
        chk("R10", "mode back to idle", st, 5'b00010);
        airq = 1'b1;
        step();
        airq = 1'b0;
    endtask

    task automatic t_off();
        wr_cfg(3'd3, 1'b1);
        pulse_wfi();
        chk("R11", "off entered", st, 5'b10000);
        chk("R11", "all off", {cpu_en, main_en, bus_en, gclk_en, osc_en, regm, nvm, bkdom}, 0);
        brst = 1'b1; airq = 1'b1;
        step();
        brst = 1'b0; airq = 1'b0;
        chk("R11", "only pin leaves off", st, 5'b10000);
        ext_rst_n = 1'b0;
        step();
        ext_rst_n = 1'b1;
        chk("R12", "pin wakes off", st, 5'b00001);
        chk("R12", "ioret cleared", ioret, 0);
        wr_cfg(3'd1, 1'b0);
        pulse_wfi();
        chk("R12", "standby before pin", st, 5'b00100);
        ext_rst_n = 1'b0;
        step();
        ext_rst_n = 1'b1;
        chk("R12", "pin wakes standby", st, 5'b00001);
        pulse_wfi();
        chk("R12", "mode cleared to idle", st, 5'b00010);
        chk("R14", "one bit set", $countones(st), 1);
        airq = 1'b1;
        step();
        airq = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset_pre();
    end

    task automatic t_reset_pre();
        t_reset_hold();
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_unused_code();
        t_soe();
        t_standby();
        t_cancel();
        t_backup();
        t_off();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic t_reset_hold();
        chk("R1", "state in reset", st, 5'b00001);
    endtask

endmodule